// File: doc/BRIEF.md
# Pseudo-DMA Bus Wait-State Controller

This block sits between a processor bus and the programmed data port of a SCSI controller. When the processor starts a bus cycle aimed at that port, the block holds the bus not-ready until the controller is prepared. The controller shows this by raising its data request or its interrupt. The block then drives a peripheral read or write strobe together with DMA acknowledge, or an end-of-process strobe, and releases the bus. Cycles that do not target the port pass through untouched.

The block has no reset input. It returns to idle through ordinary clocked transitions: any clock edge at which the combined port select (slow-device select and SCSI select, both active low) is not present sends it to idle. Every state encoding has a defined successor, so a power-up value cannot trap it. The strobe pulse width is the parameter `STROBE_CYCLES`. The address bit that marks the data port is compared with the parameter `PORT_ADDR_VAL`. Every output is a register loaded on the rising clock edge.

Top module: `pd_wait_ctrl`

## Requirements
- R1: The block has no reset port. After one rising edge at which `slow_sel_n` or `scsi_sel_n` is high, the outputs show idle: `bus_wait_n`, `pd_rd_n`, `pd_wr_n`, `dma_ack_n` and `end_proc_n` are all 1.
- R2: A qualified start moves the block from idle to waiting at the next edge. A qualified start means `cyc_start_n`=0, `slow_sel_n`=0, `scsi_sel_n`=0 and `port_addr`=`PORT_ADDR_VAL` (default 1), with `drq`=0 and `scsi_irq`=0. While waiting, `bus_wait_n`=0 and all four strobes are 1.
- R3: From any state, an edge at which `slow_sel_n` or `scsi_sel_n` is 1 returns the block to idle, even in the middle of a strobe pulse.
- R4: While waiting with the port selected, `drq`=1 starts a transfer pulse at the next edge. The pulse holds `dma_ack_n`=0 and `bus_wait_n`=0 for `STROBE_CYCLES` clocks. During the pulse, `pd_rd_n`=0 if `xfer_dir` was 1 at the entry edge, and `pd_wr_n`=0 if it was 0. After the pulse the block goes idle with `bus_wait_n`=1.
- R5: While waiting with the port selected, `scsi_irq`=1 with `drq`=0 gives `end_proc_n`=0 and `bus_wait_n`=0 for `STROBE_CYCLES` clocks. No data strobe and no acknowledge are driven. After the pulse the block goes idle.
- R6: When `drq` and `scsi_irq` are both 1, the transfer pulse of R4 wins and `end_proc_n` stays 1.
- R7: A qualified start that arrives with `drq` or `scsi_irq` already at 1 skips the waiting state and goes directly into the pulse of R4 (or of R5 if only `scsi_irq` is 1).
- R8: In idle, a cycle without a qualified start leaves all outputs at idle. This covers `cyc_start_n`=1, either select high, or `port_addr` not equal to `PORT_ADDR_VAL`.
- R9: While waiting, with the port still selected and `drq`=`scsi_irq`=0, the block stays waiting for any number of clocks, whatever the level of `cyc_start_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs register on its rising edge |
| cyc_start_n | input | 1 | Bus-cycle start, active low, first T-state only |
| slow_sel_n | input | 1 | Slow-device select, active low |
| scsi_sel_n | input | 1 | SCSI controller select, active low |
| port_addr | input | 1 | Address bit marking the data port |
| xfer_dir | input | 1 | 1 = processor read, 0 = processor write |
| drq | input | 1 | Controller data request, active high |
| scsi_irq | input | 1 | Controller interrupt, active high |
| bus_wait_n | output | 1 | Bus not-ready, active low |
| pd_rd_n | output | 1 | Peripheral read strobe, active low |
| pd_wr_n | output | 1 | Peripheral write strobe, active low |
| dma_ack_n | output | 1 | DMA acknowledge, active low |
| end_proc_n | output | 1 | End-of-process strobe, active low |

## Verification
The bench applies all 128 input combinations from idle. For each one it checks the first state, then the rest of any pulse, then recovery through a dropped select. This sweep would catch an entry term left out of the start condition, which shows as a false stall on register accesses, or a machine that stays idle when it should wait. From the waiting state, the bench checks request against interrupt priority, which a wrong design shows by raising end-of-process during a transfer. It checks a select dropped in the middle of a pulse, which a wrong design shows by keeping its strobes active. It checks a long wait with start toggling, which a wrong design shows by releasing the bus early or stalling forever. The bench checks the read/write choice in both directions, so swapped strobes are reported.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

  typedef enum logic [1:0] {
    PDW_IDLE = 2'd0,
    PDW_WAIT = 2'd1,
    PDW_XFER = 2'd2,
    PDW_ENDP = 2'd3
  } pdw_state_e;

  typedef struct packed {
    logic wait_n;
    logic rd_n;
    logic wr_n;
    logic ack_n;
    logic eop_n;
  } pdw_out_t;

  function automatic pdw_out_t pdw_decode(input pdw_state_e st, input logic dir_rd);
    pdw_out_t o;
    o = '{wait_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, ack_n: 1'b1, eop_n: 1'b1};
    case (st)
      PDW_WAIT: o.wait_n = 1'b0;
      PDW_XFER: begin
        o.wait_n = 1'b0;
        o.ack_n  = 1'b0;
        o.rd_n   = ~dir_rd;
        o.wr_n   = dir_rd;
      end
      PDW_ENDP: begin
        o.wait_n = 1'b0;
        o.eop_n  = 1'b0;
      end
      default: ;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/pdw_qualify.sv
module pdw_qualify #(
  parameter logic PORT_ADDR_VAL = 1'b1
) (
  input  logic cyc_start_n,
  input  logic slow_sel_n,
  input  logic scsi_sel_n,
  input  logic port_addr,
  output logic port_sel,
  output logic cyc_go
);
  // Combined select: both active-low selects asserted.
  assign port_sel = ~slow_sel_n & ~scsi_sel_n;
  // Start of a cycle aimed at the data port.
  assign cyc_go   = port_sel & ~cyc_start_n & (port_addr == PORT_ADDR_VAL);
endmodule

// File: rtl/pdw_next.sv
module pdw_next
  import pdw_pkg::*;
(
  input  pdw_state_e state,
  input  logic       pulse_done,
  input  logic       port_sel,
  input  logic       cyc_go,
  input  logic       drq,
  input  logic       scsi_irq,
  output pdw_state_e nxt
);
  always_comb begin
    nxt = PDW_IDLE;
    if (!port_sel) begin
      nxt = PDW_IDLE;                   // sole path back to idle when deselected
    end else begin
      case (state)
        PDW_IDLE: begin
          if (!cyc_go)       nxt = PDW_IDLE;
          else if (drq)      nxt = PDW_XFER;
          else if (scsi_irq) nxt = PDW_ENDP;
          else               nxt = PDW_WAIT;
        end
        PDW_WAIT: begin
          if (drq)           nxt = PDW_XFER;
          else if (scsi_irq) nxt = PDW_ENDP;
          else               nxt = PDW_WAIT;
        end
        PDW_XFER: nxt = pulse_done ? PDW_IDLE : PDW_XFER;
        PDW_ENDP: nxt = pulse_done ? PDW_IDLE : PDW_ENDP;
        default:  nxt = PDW_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pdw_outreg.sv
module pdw_outreg
  import pdw_pkg::*;
#(
  parameter int STROBE_CYCLES = 1,
  localparam int CNT_W = (STROBE_CYCLES > 1) ? $clog2(STROBE_CYCLES) : 1
) (
  input  logic       clk,
  input  pdw_state_e nxt,
  input  logic       xfer_dir,
  output pdw_state_e state,
  output logic       pulse_done,
  output pdw_out_t   outs
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STROBE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             dir_q;
  logic             dir_nxt;
  logic             in_pulse;
  logic             pulse_enter;

  assign in_pulse    = (state == PDW_XFER) || (state == PDW_ENDP);
  assign pulse_enter = (nxt == PDW_XFER) && (state != PDW_XFER);
  assign dir_nxt     = pulse_enter ? xfer_dir : dir_q;
  // >= so that any power-up count still ends the pulse
  assign pulse_done  = (cnt_q >= LAST);

  always_ff @(posedge clk) begin
    state <= nxt;
    dir_q <= dir_nxt;
    if (in_pulse && (nxt == state)) cnt_q <= cnt_q + 1'b1;
    else                            cnt_q <= '0;
    outs  <= pdw_decode(nxt, dir_nxt);
  end
endmodule

// File: rtl/pd_wait_ctrl.sv
module pd_wait_ctrl
  import pdw_pkg::*;
#(
  parameter int   STROBE_CYCLES = 1,
  parameter logic PORT_ADDR_VAL = 1'b1
) (
  input  logic clk,
  input  logic cyc_start_n,
  input  logic slow_sel_n,
  input  logic scsi_sel_n,
  input  logic port_addr,
  input  logic xfer_dir,
  input  logic drq,
  input  logic scsi_irq,
  output logic bus_wait_n,
  output logic pd_rd_n,
  output logic pd_wr_n,
  output logic dma_ack_n,
  output logic end_proc_n
);
  logic       port_sel;
  logic       cyc_go;
  logic       pulse_done;
  pdw_state_e state;
  pdw_state_e nxt;
  pdw_out_t   outs;

  pdw_qualify #(.PORT_ADDR_VAL(PORT_ADDR_VAL)) u_qual (
    .cyc_start_n (cyc_start_n),
    .slow_sel_n  (slow_sel_n),
    .scsi_sel_n  (scsi_sel_n),
    .port_addr   (port_addr),
    .port_sel    (port_sel),
    .cyc_go      (cyc_go)
  );

  pdw_next u_next (
    .state      (state),
    .pulse_done (pulse_done),
    .port_sel   (port_sel),
    .cyc_go     (cyc_go),
    .drq        (drq),
    .scsi_irq   (scsi_irq),
    .nxt        (nxt)
  );

  pdw_outreg #(.STROBE_CYCLES(STROBE_CYCLES)) u_reg (
    .clk        (clk),
    .nxt        (nxt),
    .xfer_dir   (xfer_dir),
    .state      (state),
    .pulse_done (pulse_done),
    .outs       (outs)
  );

  assign bus_wait_n = outs.wait_n;
  assign pd_rd_n    = outs.rd_n;
  assign pd_wr_n    = outs.wr_n;
  assign dma_ack_n  = outs.ack_n;
  assign end_proc_n = outs.eop_n;
endmodule

// File: rtl/pdw_checker.sv
module pdw_checker #(
  parameter logic PORT_ADDR_VAL = 1'b1
) (
  input logic clk,
  input logic cyc_start_n,
  input logic slow_sel_n,
  input logic scsi_sel_n,
  input logic port_addr,
  input logic drq,
  input logic scsi_irq,
  input logic bus_wait_n,
  input logic pd_rd_n,
  input logic pd_wr_n,
  input logic dma_ack_n,
  input logic end_proc_n
);
  logic settled = 1'b0;
  logic sel;
  logic go;
  logic idle_o;
  logic wait_o;

  assign sel    = ~slow_sel_n & ~scsi_sel_n;
  assign go     = sel & ~cyc_start_n & (port_addr == PORT_ADDR_VAL);
  assign idle_o = bus_wait_n & pd_rd_n & pd_wr_n & dma_ack_n & end_proc_n;
  assign wait_o = ~bus_wait_n & pd_rd_n & pd_wr_n & dma_ack_n & end_proc_n;

  // Design is known idle after the first edge with the select absent.
  always_ff @(posedge clk) begin
    if (!sel) settled <= 1'b1;
  end

  a_r1_deselect_idle: assert property (@(posedge clk) disable iff (!settled)
    !sel |=> idle_o);

  a_r2_enter_wait: assert property (@(posedge clk) disable iff (!settled)
    (idle_o && go && !drq && !scsi_irq) |=> wait_o);

  a_r4_drq_ack: assert property (@(posedge clk) disable iff (!settled)
    (wait_o && sel && drq) |=> (!dma_ack_n && !bus_wait_n && (pd_rd_n != pd_wr_n)));

  a_r5_irq_eop: assert property (@(posedge clk) disable iff (!settled)
    (wait_o && sel && !drq && scsi_irq) |=> (!end_proc_n && pd_rd_n && pd_wr_n && dma_ack_n));

  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!settled)
    ($countones({~dma_ack_n, ~end_proc_n}) <= 1) && !(!pd_rd_n && !pd_wr_n));

  a_r8_no_start_stays_idle: assert property (@(posedge clk) disable iff (!settled)
    (idle_o && !go) |=> idle_o);

  a_r9_hold_wait: assert property (@(posedge clk) disable iff (!settled)
    (wait_o && sel && !drq && !scsi_irq) |=> wait_o);
endmodule

bind pd_wait_ctrl pdw_checker #(.PORT_ADDR_VAL(PORT_ADDR_VAL)) u_chk (
  .clk         (clk),
  .cyc_start_n (cyc_start_n),
  .slow_sel_n  (slow_sel_n),
  .scsi_sel_n  (scsi_sel_n),
  .port_addr   (port_addr),
  .drq         (drq),
  .scsi_irq    (scsi_irq),
  .bus_wait_n  (bus_wait_n),
  .pd_rd_n     (pd_rd_n),
  .pd_wr_n     (pd_wr_n),
  .dma_ack_n   (dma_ack_n),
  .end_proc_n  (end_proc_n)
);

// File: tb/pd_wait_ctrl_test.sv
`timescale 1ns/1ps
module pd_wait_ctrl_test;
  localparam int STB = 2;

  logic clk = 1'b0;
  logic cyc_start_n = 1'b1, slow_sel_n = 1'b1, scsi_sel_n = 1'b1;
  logic port_addr = 1'b0, xfer_dir = 1'b0, drq = 1'b0, scsi_irq = 1'b0;
  logic bus_wait_n, pd_rd_n, pd_wr_n, dma_ack_n, end_proc_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pd_wait_ctrl #(.STROBE_CYCLES(STB), .PORT_ADDR_VAL(1'b1)) uut (
    .clk(clk), .cyc_start_n(cyc_start_n), .slow_sel_n(slow_sel_n),
    .scsi_sel_n(scsi_sel_n), .port_addr(port_addr), .xfer_dir(xfer_dir),
    .drq(drq), .scsi_irq(scsi_irq), .bus_wait_n(bus_wait_n),
    .pd_rd_n(pd_rd_n), .pd_wr_n(pd_wr_n), .dma_ack_n(dma_ack_n),
    .end_proc_n(end_proc_n)
  );

  // Expected vector order: {wait, rd, wr, ack, eop}
  localparam logic [4:0] E_IDLE = 5'b11111;
  localparam logic [4:0] E_WAIT = 5'b01111;
  localparam logic [4:0] E_RD   = 5'b00101;
  localparam logic [4:0] E_WR   = 5'b01001;
  localparam logic [4:0] E_EOP  = 5'b01110;

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {bus_wait_n, pd_rd_n, pd_wr_n, dma_ack_n, end_proc_n};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b", req, act, exp);
    end
  endtask

  task automatic deselect_and_check(input string req);
    slow_sel_n = 1'b1; scsi_sel_n = 1'b1; cyc_start_n = 1'b1;
    drq = 1'b0; scsi_irq = 1'b0;
    tick;
    check(req, E_IDLE);
  endtask

  task automatic enter_wait;
    slow_sel_n = 1'b0; scsi_sel_n = 1'b0; port_addr = 1'b1;
    drq = 1'b0; scsi_irq = 1'b0; cyc_start_n = 1'b0;
    tick;
    check("R2 enter wait", E_WAIT);
    cyc_start_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: no reset pin; one deselected edge reaches idle
    #1;
    tick;
    check("R1 idle after deselected edge", E_IDLE);
    tick;
    check("R1 idle held", E_IDLE);

    // Sweep all combinations from idle (R2, R7, R8)
    for (int i = 0; i < 128; i++) begin
      logic [4:0] exp;
      logic [4:0] pulse;
      logic q;
      {cyc_start_n, slow_sel_n, scsi_sel_n, port_addr, drq, scsi_irq, xfer_dir} = 7'(i);
      q = !cyc_start_n && !slow_sel_n && !scsi_sel_n && port_addr;
      pulse = drq ? (xfer_dir ? E_RD : E_WR) : E_EOP;
      if (!q)                 exp = E_IDLE;
      else if (drq||scsi_irq) exp = pulse;
      else                    exp = E_WAIT;
      tick;
      if (!q) check("R8 unqualified cycle stays idle", exp);
      else if (drq && scsi_irq) check("R6 R7 drq wins at start", exp);
      else if (drq || scsi_irq) check("R7 direct to pulse", exp);
      else check("R2 qualified start waits", exp);
      cyc_start_n = 1'b1;
      if (q && (drq || scsi_irq)) begin
        for (int k = 1; k < STB; k++) begin
          tick;
          check("R4 R5 pulse width", pulse);
        end
        tick;
        check("R4 R5 idle after pulse", E_IDLE);
      end else if (q) begin
        tick;
        check("R9 wait held", E_WAIT);
      end else begin
        tick;
        check("R8 still idle", E_IDLE);
      end
      deselect_and_check("R3 deselect returns idle");
    end

    // Long wait then drq read (R9, R4)
    enter_wait;
    for (int k = 0; k < 20; k++) begin
      cyc_start_n = k[0];
      tick;
      check("R9 long wait", E_WAIT);
    end
    cyc_start_n = 1'b1;
    xfer_dir = 1'b1; drq = 1'b1;
    tick;
    check("R4 read pulse", E_RD);
    xfer_dir = 1'b0;
    tick;
    check("R4 read pulse keeps entry direction", E_RD);
    drq = 1'b0;
    tick;
    check("R4 idle after read", E_IDLE);
    deselect_and_check("R3 cleanup");

    // Write direction (R4)
    enter_wait;
    xfer_dir = 1'b0; drq = 1'b1;
    tick;
    check("R4 write pulse", E_WR);
    tick;
    check("R4 write pulse second", E_WR);
    tick;
    check("R4 idle after write", E_IDLE);
    deselect_and_check("R3 cleanup");

    // Interrupt (R5)
    enter_wait;
    scsi_irq = 1'b1;
    tick;
    check("R5 end-of-process pulse", E_EOP);
    tick;
    check("R5 end-of-process second", E_EOP);
    scsi_irq = 1'b0;
    tick;
    check("R5 idle after eop", E_IDLE);
    deselect_and_check("R3 cleanup");

    // Both at once (R6)
    enter_wait;
    xfer_dir = 1'b1; drq = 1'b1; scsi_irq = 1'b1;
    tick;
    check("R6 drq priority over irq", E_RD);
    deselect_and_check("R3 deselect mid pulse");

    // Deselect while waiting via slow select only (R3)
    enter_wait;
    slow_sel_n = 1'b1;
    tick;
    check("R3 slow select drop in wait", E_IDLE);
    deselect_and_check("R3 cleanup");

    // Deselect mid eop pulse via scsi select only (R3)
    enter_wait;
    scsi_irq = 1'b1;
    tick;
    check("R5 eop before abort", E_EOP);
    scsi_sel_n = 1'b1;
    tick;
    check("R3 scsi select drop mid pulse", E_IDLE);
    deselect_and_check("R3 cleanup");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule